// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Controller

This block is the digital half of a tuner's frequency synthesizer loop. It works with an external prescaler that divides by 32 or by 33. Software writes a tuning word that counts 625 kHz steps of the wanted local-oscillator frequency. From that word the block decides whether the external frequency doubler is used, and derives a main count B and a swallow count A. The total division is N = 32·B + A.

In every division cycle the block counts B prescaler output pulses. For the first A of them it asks the prescaler for the ratio of 33, and for the rest it asks for 32. On the last pulse it emits a one-clock feedback pulse to the phase detector. Because the modulus changes inside each cycle, the prescaler does not coarsen the step.

A newly accepted word is held aside and only swapped in at a cycle boundary, so no cycle mixes old and new counts. A window counter compares feedback pulses with ticks of the divided reference and reports lock.

Top module: `dms_synth_ctrl`

## Requirements
- R1: While reset is held, `fb_pulse`, `tune_err` and `lock` are 0 and `dbl_out` is 0 with `dbl_oe` 1. `mod_sel` is 1, because the reset word 1610 gives A = 10. After reset the active counts are B = 50, A = 10, and the doubler is off.
- R2: Each division cycle ends after exactly B `pre_pulse` strobes. `fb_pulse` is high for the single clock after the strobe that ends the cycle, and never otherwise.
- R3: Within a cycle, `mod_sel` (1 = divide by 33) is high while the first A strobes arrive and low for the remaining B − A. Its value when a strobe is presented is the modulus of the period that strobe ends.
- R4: A word W below 1738 gives N = W with the doubler off. A word of 1738 or more gives N = W/2 with the doubler on. In both cases B = N div 32 and A = N mod 32.
- R5: A word is rejected if W < 1480, W > 3480, W ≥ 1738 with W odd, or B < A. On rejection `tune_err` rises one clock after the write and stays set until reset, and the counts in use and already pending are kept.
- R6: An accepted word takes effect at the next cycle boundary. The cycle in progress completes with the previous B and A.
- R7: `dbl_out` shows the doubler state of the active counts and changes only together with a feedback pulse. `dbl_oe` is 0 (high-impedance) only while `hrr_mode` is 1 and the doubler is off, and follows a change of `hrr_mode` one clock later.
- R8: On every LOCK_WIN-th `ref_tick`, `lock` becomes 1 if the feedback pulses counted since the previous evaluation, including one coinciding with the closing tick, number LOCK_WIN ± LOCK_TOL. Otherwise it becomes 0. Between evaluations `lock` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the tuning word |
| wr_word | input | WORD_W | Tuning word in 625 kHz units |
| hrr_mode | input | 1 | Half-harmonic rejection mode: float the doubler line when the doubler is off |
| pre_pulse | input | 1 | One-clock strobe per prescaler output period, already synchronized |
| ref_tick | input | 1 | One-clock strobe per divided-reference period |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide by 33 |
| fb_pulse | output | 1 | One-clock feedback pulse per division cycle |
| dbl_out | output | 1 | Doubler control level |
| dbl_oe | output | 1 | Doubler control drive enable, 0 = high-impedance |
| tune_err | output | 1 | Sticky rejected-word flag |
| lock | output | 1 | Feedback rate matches reference rate |

## Verification
The bench keeps the default tuning range, doubler threshold and reset word, so every band edge can be written directly. These edges are 1480, 1737, 1738 and 3480, plus the B < A corner at 1790 and the A = 0 word 1792. It builds the block with LOCK_WIN = 8 and LOCK_TOL = 1. With those values a lock evaluation closes every eight reference ticks, so both the gained-lock and lost-lock outcomes are reached within a few thousand clocks.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // Low ratio of the external prescaler; must be a power of two.
  localparam int PRE_LOW = 32;
  localparam int SWAL_W  = $clog2(PRE_LOW);
  localparam int MAIN_W  = 8;

  typedef struct packed {
    logic [MAIN_W-1:0] b;    // prescaler pulses per division cycle
    logic [SWAL_W-1:0] a;    // pulses taken at the high ratio
    logic              dbl;  // doubler enabled
  } div_cfg_t;
endpackage

// File: rtl/dms_word_decode.sv
module dms_word_decode
  import dms_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int LO_MIN  = 1480,
  parameter int LO_MAX  = 3480,
  parameter int DBL_MIN = 1738
) (
  input  logic [WORD_W-1:0] word,
  output logic              ok,
  output div_cfg_t          cfg
);
  localparam logic [WORD_W-1:0] MIN_W = WORD_W'(LO_MIN);
  localparam logic [WORD_W-1:0] MAX_W = WORD_W'(LO_MAX);
  localparam logic [WORD_W-1:0] DBL_W = WORD_W'(DBL_MIN);

  logic              dbl;
  logic [WORD_W-1:0] n;
  logic              in_range;
  logic              odd_dbl;
  logic              swal_fits;

  always_comb begin
    dbl       = (word >= DBL_W);
    n         = dbl ? (word >> 1) : word;
    cfg.dbl   = dbl;
    cfg.a     = n[SWAL_W-1:0];
    cfg.b     = MAIN_W'(n >> SWAL_W);
    in_range  = (word >= MIN_W) && (word <= MAX_W);
    odd_dbl   = dbl && word[0];
    swal_fits = (cfg.b >= MAIN_W'(cfg.a));
    ok        = in_range && !odd_dbl && swal_fits;
  end
endmodule

// File: rtl/dms_swallow_counter.sv
module dms_swallow_counter
  import dms_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pre_pulse,
  input  div_cfg_t next_cfg,
  output div_cfg_t act_cfg,
  output logic     mod_hi,
  output logic     fb_pulse
);
  logic [MAIN_W-1:0] cnt;
  logic [MAIN_W-1:0] cnt_nx;
  div_cfg_t          cfg_nx;
  logic              wrap;

  always_comb begin
    wrap   = pre_pulse && (cnt == act_cfg.b - 1'b1);
    cfg_nx = wrap ? next_cfg : act_cfg;
    if (!pre_pulse)  cnt_nx = cnt;
    else if (wrap)   cnt_nx = '0;
    else             cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act_cfg  <= RST_CFG;
      mod_hi   <= (RST_CFG.a != '0);
      fb_pulse <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      act_cfg  <= cfg_nx;
      mod_hi   <= (cnt_nx < MAIN_W'(cfg_nx.a));
      fb_pulse <= wrap;
    end
  end
endmodule

// File: rtl/dms_lock_monitor.sv
module dms_lock_monitor #(
  parameter int LOCK_WIN = 16,
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic fb_pulse,
  output logic lock
);
  localparam int WIN_W = $clog2(LOCK_WIN + 1);
  localparam int FB_W  = $clog2(LOCK_WIN + LOCK_TOL + 3) + 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(LOCK_WIN - 1);
  localparam logic [FB_W-1:0]  LO   = FB_W'(LOCK_WIN - LOCK_TOL);
  localparam logic [FB_W-1:0]  HI   = FB_W'(LOCK_WIN + LOCK_TOL);
  localparam logic [FB_W-1:0]  SAT  = HI + 1'b1;

  logic [WIN_W-1:0] ref_cnt;
  logic [FB_W-1:0]  fb_cnt;
  logic [FB_W-1:0]  fb_tot;
  logic [FB_W-1:0]  fb_sat;

  always_comb begin
    fb_tot = fb_cnt + FB_W'(fb_pulse);
    fb_sat = (fb_tot > SAT) ? SAT : fb_tot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
      lock    <= 1'b0;
    end else if (ref_tick) begin
      if (ref_cnt == LAST) begin
        lock    <= (fb_tot >= LO) && (fb_tot <= HI);
        ref_cnt <= '0;
        fb_cnt  <= '0;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
        fb_cnt  <= fb_sat;
      end
    end else if (fb_pulse) begin
      fb_cnt <= fb_sat;
    end
  end
endmodule

// File: rtl/dms_synth_ctrl.sv
module dms_synth_ctrl
  import dms_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int LO_MIN     = 1480,
  parameter int LO_MAX     = 3480,
  parameter int DBL_MIN    = 1738,
  parameter int RESET_WORD = 1610,
  parameter int LOCK_WIN   = 16,
  parameter int LOCK_TOL   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              hrr_mode,
  input  logic              pre_pulse,
  input  logic              ref_tick,
  output logic              mod_sel,
  output logic              fb_pulse,
  output logic              dbl_out,
  output logic              dbl_oe,
  output logic              tune_err,
  output logic              lock
);
  localparam bit       RST_DBL = (RESET_WORD >= DBL_MIN);
  localparam int       RST_N   = RST_DBL ? RESET_WORD / 2 : RESET_WORD;
  localparam div_cfg_t RST_CFG = '{b:   MAIN_W'(RST_N / PRE_LOW),
                                   a:   SWAL_W'(RST_N % PRE_LOW),
                                   dbl: RST_DBL};

  logic     dec_ok;
  div_cfg_t dec_cfg;
  div_cfg_t pend_cfg;
  div_cfg_t act_cfg;
  logic     hrr_q;

  dms_word_decode #(
    .WORD_W (WORD_W),
    .LO_MIN (LO_MIN),
    .LO_MAX (LO_MAX),
    .DBL_MIN(DBL_MIN)
  ) u_decode (
    .word(wr_word),
    .ok  (dec_ok),
    .cfg (dec_cfg)
  );

  // Accepted words wait here until the running cycle ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cfg <= RST_CFG;
      tune_err <= 1'b0;
      hrr_q    <= 1'b0;
    end else begin
      hrr_q <= hrr_mode;
      if (wr_en) begin
        if (dec_ok) pend_cfg <= dec_cfg;
        else        tune_err <= 1'b1;
      end
    end
  end

  dms_swallow_counter #(
    .RST_CFG(RST_CFG)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .pre_pulse(pre_pulse),
    .next_cfg (pend_cfg),
    .act_cfg  (act_cfg),
    .mod_hi   (mod_sel),
    .fb_pulse (fb_pulse)
  );

  dms_lock_monitor #(
    .LOCK_WIN(LOCK_WIN),
    .LOCK_TOL(LOCK_TOL)
  ) u_lock (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .fb_pulse(fb_pulse),
    .lock    (lock)
  );

  assign dbl_out = act_cfg.dbl;
  assign dbl_oe  = ~(hrr_q & ~act_cfg.dbl);
endmodule

// File: rtl/dms_synth_ctrl_chk.sv
module dms_synth_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic pre_pulse,
  input logic ref_tick,
  input logic mod_sel,
  input logic fb_pulse,
  input logic dbl_out,
  input logic tune_err,
  input logic lock
);
  assert_fb_single_R2: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  assert_fb_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> $past(pre_pulse));

  assert_mod_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !pre_pulse |=> $stable(mod_sel));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    tune_err |=> tune_err);

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(tune_err) |-> $past(wr_en));

  assert_dbl_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dbl_out) |-> fb_pulse);

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(lock));
endmodule

bind dms_synth_ctrl dms_synth_ctrl_chk u_chk (.*);

// File: tb/dms_synth_ctrl_bench.sv
module dms_synth_ctrl_bench;
  localparam int WORD_W     = 12;
  localparam int LO_MIN     = 1480;
  localparam int LO_MAX     = 3480;
  localparam int DBL_MIN    = 1738;
  localparam int RESET_WORD = 1610;
  localparam int LOCK_WIN   = 8;
  localparam int LOCK_TOL   = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [WORD_W-1:0] wr_word = '0;
  logic hrr_mode = 1'b0;
  logic pre_pulse = 1'b0;
  logic ref_tick = 1'b0;
  logic mod_sel, fb_pulse, dbl_out, dbl_oe, tune_err, lock;

  always #2 clk = ~clk;

  dms_synth_ctrl #(
    .WORD_W(WORD_W), .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .DBL_MIN(DBL_MIN),
    .RESET_WORD(RESET_WORD), .LOCK_WIN(LOCK_WIN), .LOCK_TOL(LOCK_TOL)
  ) u_dms_synth_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .hrr_mode(hrr_mode),
    .pre_pulse(pre_pulse), .ref_tick(ref_tick), .mod_sel(mod_sel),
    .fb_pulse(fb_pulse), .dbl_out(dbl_out), .dbl_oe(dbl_oe),
    .tune_err(tune_err), .lock(lock)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cur_b, cur_a, pend_b, pend_a;
  bit cur_dbl, pend_dbl, err_exp;
  int cyc_pulses, cyc_hi;
  bit saw_low, order_bad, after_fb, closed;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic decode(input int w, output bit ok, output int b, output int a, output bit d);
    int n;
    d = (w >= DBL_MIN);
    n = d ? w / 2 : w;
    b = n / 32;
    a = n % 32;
    ok = (w >= LO_MIN) && (w <= LO_MAX) && !(d && (w % 2 == 1)) && (b >= a);
  endtask

  task automatic close_cycle();
    check("R2 R4 R6 prescaler pulses per cycle", cyc_pulses, cur_b);
    check("R3 R4 R6 pulses at ratio 33", cyc_hi, cur_a);
    check("R3 ratio-33 pulses come first", int'(order_bad), 0);
    cur_b = pend_b; cur_a = pend_a; cur_dbl = pend_dbl;
    check("R7 doubler level after boundary", int'(dbl_out), int'(cur_dbl));
    check("R7 doubler drive enable", int'(dbl_oe), int'(!(hrr_mode && !cur_dbl)));
    cyc_pulses = 0; cyc_hi = 0; saw_low = 0; order_bad = 0;
    after_fb = 1; closed = 1;
  endtask

  task automatic one_pulse(input int gap);
    @(negedge clk);
    if (after_fb) begin
      check("R2 feedback lasts one clock", int'(fb_pulse), 0);
      after_fb = 0;
    end
    if (mod_sel) begin
      cyc_hi++;
      if (saw_low) order_bad = 1;
    end else begin
      saw_low = 1;
    end
    pre_pulse = 1'b1;
    cyc_pulses++;
    @(negedge clk);
    pre_pulse = 1'b0;
    if (fb_pulse) close_cycle();
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      closed = 0;
      one_pulse(int'($urandom_range(2, 0)));
    end
  endtask

  task automatic finish_cycle();
    int guard = 0;
    closed = 0;
    while (!closed && guard < 400) begin
      one_pulse(int'($urandom_range(2, 0)));
      guard++;
    end
    if (!closed) check("R2 feedback pulse seen", 0, 1);
  endtask

  task automatic write_word(input int w);
    bit ok, d;
    int b, a;
    decode(w, ok, b, a, d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_word = w[WORD_W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
    if (ok) begin
      pend_b = b; pend_a = a; pend_dbl = d;
    end else begin
      err_exp = 1'b1;
    end
    check("R5 error flag after write", int'(tune_err), int'(err_exp));
  endtask

  task automatic lock_run(input int per, input int expect_lock, input string req);
    for (int c = 0; c <= 24 * per; c++) begin
      @(negedge clk);
      pre_pulse = (c % 2 == 0);
      ref_tick  = (c % per == 0);
    end
    @(negedge clk);
    pre_pulse = 1'b0;
    ref_tick  = 1'b0;
    @(negedge clk);
    check(req, int'(lock), expect_lock);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok0, d0;
    int b0, a0;
    void'($urandom(32'h5EED));
    decode(RESET_WORD, ok0, b0, a0, d0);
    cur_b = b0; cur_a = a0; cur_dbl = d0;
    pend_b = b0; pend_a = a0; pend_dbl = d0;
    err_exp = 0; cyc_pulses = 0; cyc_hi = 0; saw_low = 0; order_bad = 0;
    after_fb = 0; closed = 0;

    repeat (3) @(negedge clk);
    check("R1 reset mod_sel", int'(mod_sel), 1);
    check("R1 reset fb_pulse", int'(fb_pulse), 0);
    check("R1 reset tune_err", int'(tune_err), 0);
    check("R1 reset lock", int'(lock), 0);
    check("R1 reset dbl_out", int'(dbl_out), 0);
    check("R1 reset dbl_oe", int'(dbl_oe), 1);
    rst = 1'b0;

    finish_cycle();                       // R1 R2 R3: B=50 A=10
    run_pulses(20);                       // R6: write mid-cycle
    write_word(1480);                     // R4: B=46 A=8
    finish_cycle();
    finish_cycle();
    write_word(1737); finish_cycle(); finish_cycle();  // B=54 A=9
    write_word(1738); finish_cycle(); finish_cycle();  // R4 R7: B=27 A=5 doubled
    write_word(3480); finish_cycle(); finish_cycle();  // B=54 A=12
    write_word(1792); finish_cycle(); finish_cycle();  // B=28 A=0
    write_word(1479); finish_cycle();                  // R5 rejects
    write_word(3481); finish_cycle();
    write_word(1739); finish_cycle();
    write_word(1790); finish_cycle();

    @(negedge clk); hrr_mode = 1'b1;
    @(negedge clk);
    check("R7 hrr with doubler on keeps drive", int'(dbl_oe), 1);
    write_word(1480); finish_cycle(); finish_cycle();  // R7: floats once doubler off
    @(negedge clk); hrr_mode = 1'b0;
    @(negedge clk);
    check("R7 drive restored one clock after hrr off", int'(dbl_oe), 1);

    for (int i = 0; i < 20; i++) begin
      int w = int'($urandom_range(3490, 1470));
      run_pulses(int'($urandom_range(5, 0)));
      write_word(w);
      finish_cycle();
      finish_cycle();
    end

    lock_run(2 * cur_b, 1, "R8 lock at matching rate");
    lock_run(cur_b, 0, "R8 lock lost at half rate");
    check("R5 error flag still set", int'(tune_err), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule